// File: doc/BRIEF.md
# Dual Countdown Timer with Shared Interrupt

This block holds two independent down-counters behind one small register window, with one interrupt line for both. Software sets a reload value for each timer and then writes that timer's control register. The write loads the counter from its reload value and picks a tick rate and a run mode. The live count can be read back at any time. When a timer runs out, it sets its own bit in a sticky raw interrupt vector. A mask register gates that vector and a write-one-to-clear acknowledge register clears it. The level interrupt output is high whenever any gated bit is set.

Tick rates do not come from separate clocks. Each timer carries a small prescaler that counts cycles of the one system clock and produces an enable pulse every `RATIO_C4`, `RATIO_C5`, `RATIO_C6` or `RATIO_C7` cycles. The ratios are parameters, ordered from slowest to fastest (`RATIO_C4` >= `RATIO_C5` >= `RATIO_C6` >= `RATIO_C7` >= 1). Rate codes below 4 stand for a clock source that is absent or switched off, and the timer holds its count.

Top module: `dual_tmr_irq`

## Requirements
- R1: After reset every register reads zero, both timers are stopped and `irq_o` is low.
- R2: Register offsets are as follows. Timer n's reload value is at 0x00 + 0x10·n, its live count at 0x04 + 0x10·n and its control at 0x08 + 0x10·n. The mask is at 0x48, acknowledge at 0x4C and masked status at 0x54. Reload, control and mask read back what was written, limited to their widths: control keeps bits [3:0] and mask keeps bits [1:0]. Acknowledge and every other offset read zero.
- R3: A write to a timer's control register loads that timer's count from its current reload value on the next clock edge. The count register always returns the live count.
- R4: Control bits [2:0] hold the rate code. Codes 4, 5, 6 and 7 move the count down once every `RATIO_C4`, `RATIO_C5`, `RATIO_C6` and `RATIO_C7` cycles, counting from the control write. Codes 0 to 3 leave the count frozen.
- R5: With control bit 3 set (periodic), a tick that finds a count of 1 or 0 signals expiry and reloads the current reload value, so expiry repeats every max(reload, 1) ticks.
- R6: With control bit 3 clear (one-shot), that same tick signals expiry once, leaves the count at zero and stops the timer until its control register is written again.
- R7: Expiry of timer 0 sets raw bit 0 and expiry of timer 1 sets raw bit 1. A raw bit stays set until it is acknowledged.
- R8: Writing to acknowledge clears each raw bit whose write-data bit is 1 and leaves the others alone. When expiry and acknowledge reach the same bit in the same cycle, the bit stays set.
- R9: Status bits [1:0] read raw AND mask, and `irq_o` is the OR of those two bits. With the mask at zero, `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt, OR of the masked status bits |

## Verification
A wrong count or prescaler phase shows up in the count register on the first cycle it differs, because the bench compares every read with a cycle-accurate model. A wrong run flag or reload takes longer to show. It appears as a raw bit that sets or clears one tick early or late, which reaches the status register and `irq_o` on that same edge if the mask is open. It is hidden while the mask is closed. Faults in raw-bit stickiness and in acknowledge priority show in the status register the cycle after the acknowledge write.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    // Register window byte offsets
    localparam int OFF_RELOAD = 'h00;
    localparam int OFF_COUNT  = 'h04;
    localparam int OFF_CTRL   = 'h08;
    localparam int TMR_STRIDE = 'h10;
    localparam int OFF_MASK   = 'h48;
    localparam int OFF_ACK    = 'h4C;
    localparam int OFF_STAT   = 'h54;

    // Control register layout
    localparam int CTRL_W        = 4;
    localparam int CTRL_PERIODIC = 3;

    localparam int NUM_TMR = 2;

endpackage

// File: rtl/dtmr_tick.sv
module dtmr_tick #(
    parameter int RATIO_C4 = 8,
    parameter int RATIO_C5 = 4,
    parameter int RATIO_C6 = 2,
    parameter int RATIO_C7 = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic       active_i,
    input  logic [2:0] rate_i,
    output logic       tick_o
);
    localparam int PRE_W = (RATIO_C4 > 1) ? $clog2(RATIO_C4) : 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } tick_st_t;

    tick_st_t         st_d, st_q;
    logic [PRE_W-1:0] lim;
    logic             rate_ok;

    always_comb begin
        rate_ok = rate_i[2];
        case (rate_i[1:0])
            2'd0:    lim = PRE_W'(RATIO_C4 - 1);
            2'd1:    lim = PRE_W'(RATIO_C5 - 1);
            2'd2:    lim = PRE_W'(RATIO_C6 - 1);
            default: lim = PRE_W'(RATIO_C7 - 1);
        endcase
        tick_o = active_i && rate_ok && (st_q.pre == lim);
        st_d   = st_q;
        if (restart_i) begin
            st_d.pre = '0;
        end else if (active_i && rate_ok) begin
            st_d.pre = tick_o ? '0 : st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the prescaler never runs past the limit of the selected rate
    a_r4_pre_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && rate_ok) |-> (st_q.pre <= lim));

endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
    import dtmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int RATIO_C4 = 8,
    parameter int RATIO_C5 = 4,
    parameter int RATIO_C6 = 2,
    parameter int RATIO_C7 = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CTRL_W-1:0] ctrl;
        logic              run;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     tick;

    dtmr_tick #(
        .RATIO_C4 (RATIO_C4),
        .RATIO_C5 (RATIO_C5),
        .RATIO_C6 (RATIO_C6),
        .RATIO_C7 (RATIO_C7)
    ) tick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ctrl_wr_i),
        .active_i  (st_q.run),
        .rate_i    (st_q.ctrl[2:0]),
        .tick_o    (tick)
    );

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (ctrl_wr_i) begin
            st_d.cnt  = reload_i;
            st_d.ctrl = ctrl_i;
            st_d.run  = ctrl_i[2];
        end else if (tick) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                expire_o = 1'b1;
                if (st_q.ctrl[CTRL_PERIODIC]) begin
                    st_d.cnt = reload_i;
                end else begin
                    st_d.cnt = '0;
                    st_d.run = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign ctrl_o = st_q.ctrl;

    // R3: a control write loads the reload value
    a_r3_load_on_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_i |=> (st_q.cnt == $past(reload_i)));

    // R4: without a tick or a control write the count holds
    a_r4_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr_i && !tick) |=> $stable(st_q.cnt));

    // R5: periodic expiry reloads
    a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && st_q.ctrl[CTRL_PERIODIC]) |=> (st_q.cnt == $past(reload_i)));

    // R6: one-shot expiry halts at zero
    a_r6_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !st_q.ctrl[CTRL_PERIODIC]) |=> (!st_q.run && st_q.cnt == '0));

endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] expire_i,
    input  logic         ack_wr_i,
    input  logic [N-1:0] ack_bits_i,
    input  logic         mask_wr_i,
    input  logic [N-1:0] mask_bits_i,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] masked_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] raw;
        logic [N-1:0] mask;
    } irq_st_t;

    irq_st_t      st_d, st_q;
    logic [N-1:0] clr;

    always_comb begin
        st_d      = st_q;
        clr       = ack_wr_i ? ack_bits_i : '0;
        st_d.raw  = (st_q.raw & ~clr) | expire_i;
        if (mask_wr_i) st_d.mask = mask_bits_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o   = st_q.mask;
    assign masked_o = st_q.raw & st_q.mask;
    assign irq_o    = |masked_o;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // R8: expiry beats a same-cycle acknowledge
        a_r8_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
            expire_i[i] |=> st_q.raw[i]);
        // R8: acknowledge clears the bit
        a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_wr_i && ack_bits_i[i] && !expire_i[i]) |=> !st_q.raw[i]);
        // R7: a raw bit is sticky until acknowledged
        a_r7_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.raw[i] && !(ack_wr_i && ack_bits_i[i])) |=> st_q.raw[i]);
    end

    // R9: a closed mask keeps the line low
    a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |-> !irq_o);

endmodule

// File: rtl/dual_tmr_irq.sv
module dual_tmr_irq
    import dtmr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 32,
    parameter int RATIO_C4 = 8,
    parameter int RATIO_C5 = 4,
    parameter int RATIO_C6 = 2,
    parameter int RATIO_C7 = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_TMR-1:0][CNT_W-1:0] reload;
    } top_st_t;

    top_st_t            st_d, st_q;
    logic [NUM_TMR-1:0] sel_reload, sel_ctrl, expire;
    logic [CNT_W-1:0]   cnt_w  [NUM_TMR];
    logic [CTRL_W-1:0]  ctrl_w [NUM_TMR];
    logic [NUM_TMR-1:0] mask_w, masked_w;
    logic               sel_mask, sel_ack;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        assign sel_reload[i] = bus_wr && (bus_addr == ADDR_W'(OFF_RELOAD + i * TMR_STRIDE));
        assign sel_ctrl[i]   = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL + i * TMR_STRIDE));

        dtmr_chan #(
            .CNT_W    (CNT_W),
            .RATIO_C4 (RATIO_C4),
            .RATIO_C5 (RATIO_C5),
            .RATIO_C6 (RATIO_C6),
            .RATIO_C7 (RATIO_C7)
        ) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .reload_i  (st_q.reload[i]),
            .ctrl_wr_i (sel_ctrl[i]),
            .ctrl_i    (bus_wdata[CTRL_W-1:0]),
            .cnt_o     (cnt_w[i]),
            .ctrl_o    (ctrl_w[i]),
            .expire_o  (expire[i])
        );
    end

    assign sel_mask = bus_wr && (bus_addr == ADDR_W'(OFF_MASK));
    assign sel_ack  = bus_wr && (bus_addr == ADDR_W'(OFF_ACK));

    dtmr_irq #(
        .N (NUM_TMR)
    ) irq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire_i    (expire),
        .ack_wr_i    (sel_ack),
        .ack_bits_i  (bus_wdata[NUM_TMR-1:0]),
        .mask_wr_i   (sel_mask),
        .mask_bits_i (bus_wdata[NUM_TMR-1:0]),
        .mask_o      (mask_w),
        .masked_o    (masked_w),
        .irq_o       (irq_o)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (sel_reload[i]) st_d.reload[i] = bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr == ADDR_W'(OFF_RELOAD + i * TMR_STRIDE)) bus_rdata = 32'(st_q.reload[i]);
            if (bus_addr == ADDR_W'(OFF_COUNT + i * TMR_STRIDE))  bus_rdata = 32'(cnt_w[i]);
            if (bus_addr == ADDR_W'(OFF_CTRL + i * TMR_STRIDE))   bus_rdata = 32'(ctrl_w[i]);
        end
        if (bus_addr == ADDR_W'(OFF_MASK)) bus_rdata = 32'(mask_w);
        if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata = 32'(masked_w);
    end

    // R2: a reload write is visible on the next cycle
    a_r2_reload_written: assert property (@(posedge clk) disable iff (!rst_n)
        sel_reload[0] |=> (st_q.reload[0] == $past(bus_wdata[CNT_W-1:0])));

endmodule

// File: tb/dual_tmr_irq_tb_top.sv
module dual_tmr_irq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    always #5 clk = ~clk;

    dual_tmr_irq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [31:0] m_rel  [2];
    logic [31:0] m_cnt  [2];
    logic [3:0]  m_ctl  [2];
    logic        m_run  [2];
    int          m_pre  [2];
    logic [1:0]  m_mask;
    logic [1:0]  m_raw;

    function automatic int ratio_of(input logic [2:0] code);
        case (code)
            3'd4:    return 8;
            3'd5:    return 4;
            3'd6:    return 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 2; i++) begin
            if (a == 8'(16 * i))     r = m_rel[i];
            if (a == 8'(16 * i + 4)) r = m_cnt[i];
            if (a == 8'(16 * i + 8)) r = {28'd0, m_ctl[i]};
        end
        if (a == 8'h48) r = {30'd0, m_mask};
        if (a == 8'h54) r = {30'd0, m_raw & m_mask};
        return r;
    endfunction

    always @(posedge clk) begin : model
        logic [1:0] ex;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_rel[i] = '0; m_cnt[i] = '0; m_ctl[i] = '0; m_run[i] = 1'b0; m_pre[i] = 0;
            end
            m_mask = '0;
            m_raw  = '0;
        end else begin
            ex = '0;
            for (int i = 0; i < 2; i++) begin
                if (wr && addr == 8'(16 * i + 8)) begin
                    m_cnt[i] = m_rel[i];
                    m_ctl[i] = wdata[3:0];
                    m_run[i] = wdata[2];
                    m_pre[i] = 0;
                end else if (m_run[i]) begin
                    if (m_pre[i] == ratio_of(m_ctl[i][2:0]) - 1) begin
                        m_pre[i] = 0;
                        if (m_cnt[i] <= 1) begin
                            ex[i] = 1'b1;
                            if (m_ctl[i][3]) m_cnt[i] = m_rel[i];
                            else begin m_cnt[i] = '0; m_run[i] = 1'b0; end
                        end else begin
                            m_cnt[i] = m_cnt[i] - 1;
                        end
                    end else begin
                        m_pre[i] = m_pre[i] + 1;
                    end
                end
                if (wr && addr == 8'(16 * i)) m_rel[i] = wdata;
            end
            m_raw = (m_raw & ~((wr && addr == 8'h4C) ? wdata[1:0] : 2'b00)) | ex;
            if (wr && addr == 8'h48) m_mask = wdata[1:0];
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // One bus cycle; compares read data and interrupt against the model
    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        wr = w; addr = a; wdata = d;
        #3;
        chk(tag, rdata, model_read(a));
        chk("R9 irq line", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
    endtask

    initial begin : watchdog
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [7:0] addrs [10];
        logic [7:0] a;
        logic [31:0] d;
        void'($urandom(32'h5EED_1234));
        addrs = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h48, 8'h4C, 8'h54, 8'h30};
        rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        foreach (addrs[k]) begin
            step(0, addrs[k], 0, "R1 reset read");
            chk("R1 reset zero", rdata, 32'd0);
        end

        // R2: readback and unmapped offsets
        step(1, 8'h00, 32'h1234_5678, "R2 write reload");
        step(0, 8'h00, 0, "R2 reload readback");
        chk("R2 reload value", rdata, 32'h1234_5678);
        step(1, 8'h18, 32'hFFFF_FFF2, "R2 ctrl write");
        step(0, 8'h18, 0, "R2 ctrl readback");
        chk("R2 ctrl width", rdata, 32'h2);
        step(0, 8'h20, 0, "R2 unmapped");
        step(0, 8'h4C, 0, "R2 ack reads zero");
        step(0, 8'h58, 0, "R2 unmapped high");

        // R4: slow code freezes the count; R3 load
        step(1, 8'h00, 32'd5, "R4 reload");
        step(1, 8'h08, 32'hA, "R4 ctrl code 2");
        for (int k = 0; k < 10; k++) begin
            step(0, 8'h04, 0, "R3 R4 frozen count");
            chk("R4 frozen at reload", rdata, 32'd5);
        end

        // R6: one-shot fires once
        step(1, 8'h48, 32'h3, "R9 mask");
        step(1, 8'h00, 32'd3, "R6 reload");
        step(1, 8'h08, 32'h7, "R6 oneshot start");
        for (int k = 0; k < 8; k++) step(0, 8'h04, 0, "R6 count");
        chk("R6 count at zero", rdata, 32'd0);
        step(0, 8'h54, 0, "R7 status");
        chk("R7 raw bit0 set", rdata, 32'd1);
        step(1, 8'h4C, 32'h1, "R8 ack bit0");
        for (int k = 0; k < 10; k++) step(0, 8'h54, 0, "R6 no refire");
        chk("R6 single expiry", rdata, 32'd0);

        // R8: expiry beats acknowledge
        step(1, 8'h10, 32'd1, "R8 reload1");
        step(1, 8'h18, 32'hF, "R8 ctrl1 every cycle");
        repeat (3) step(0, 8'h54, 0, "R8 wait");
        for (int k = 0; k < 5; k++) step(1, 8'h4C, 32'h2, "R8 ack vs expiry");
        step(0, 8'h54, 0, "R8 status after ack");
        chk("R8 expiry wins", rdata, 32'h2);
        step(1, 8'h18, 32'h0, "R8 stop timer1");
        step(1, 8'h4C, 32'h3, "R8 ack all");
        step(0, 8'h54, 0, "R8 cleared");
        chk("R8 cleared bits", rdata, 32'd0);

        // R5: periodic at slowest rate
        step(1, 8'h10, 32'd2, "R5 reload1");
        step(1, 8'h18, 32'hC, "R5 ctrl1 code4 periodic");
        for (int k = 0; k < 60; k++) step(k % 3 == 0, (k % 2 == 0) ? 8'h14 : 8'h4C,
                                           32'h2, "R5 periodic count");
        // R9: mask closed keeps irq low
        step(1, 8'h48, 32'h0, "R9 mask off");
        for (int k = 0; k < 20; k++) begin
            step(0, 8'h54, 0, "R9 masked status");
            chk("R9 irq low", {31'd0, irq}, 32'd0);
        end

        // Constrained random traffic
        for (int k = 0; k < 3000; k++) begin
            a = addrs[$urandom_range(0, 9)];
            d = $urandom;
            if (a == 8'h00 || a == 8'h10) d = $urandom_range(0, 6);
            if (a == 8'h08 || a == 8'h18) d = {28'd0, 1'b1, d[2:0] | 3'b100} ^ {28'd0, 4'($urandom_range(0, 1)) << 2};
            step(($urandom_range(0, 9) < 4), a, d, "R3 R5 R6 R7 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule